// File: doc/BRIEF.md
# Segmented DAC Digital Front End

This block is the digital input path of an 8-bit segmented resistor-ladder converter. An 8-bit data word enters together with a complement control and an active-low latch enable. Every data bit is first optionally inverted. The three most significant bits of the result are then expanded into seven thermometer (bar-graph) lines, which drive equally weighted upper segments. The five least significant bits stay in binary form and drive the lower binary-weighted ladder taps.

The twelve resulting driver-control lines pass through a level-sensitive latch. While the enable is low, the latch is transparent, so with the enable tied low the block acts as plain combinational logic. When the enable rises, the latch keeps the value that was present at that edge. Any later low pulse on the enable loads a new value. No free-running clock is involved. The ladder, the references, level shifting and analog settling are outside this block.

Top module: `seg_dac_frontend`

## Requirements
- R1: Bit i of `dataIn` has weight 2^i and is active high. On `segOut`, bits 11:5 are thermometer lines 6 down to 0 (line j at bit 5+j), and bits 4:0 are the binary field.
- R2: When `compIn` is 1, every data bit is inverted before encoding. When it is 0, the bits are used unchanged.
- R3: Let k be the value of processed bits 7:5 (0 to 7). Thermometer lines 0 to k-1 are 1 and the other lines are 0. For k = 0 all seven lines are 0, and for k = 7 all seven lines are 1.
- R4: `segOut[4:0]` equals processed bits 4:0.
- R5: While `latchEnN` is 0, `segOut` follows `dataIn` and `compIn` with no clock, for every code in both complement states.
- R6: On a rising edge of `latchEnN`, the encoded value present just before the edge is captured.
- R7: While `latchEnN` is 1, changes on `dataIn` or `compIn` have no effect on `segOut`.
- R8: A short low pulse on `latchEnN` replaces the held value with the encoding of the inputs present during the pulse. That value is then held after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 8 | Data word, bit 0 least significant |
| compIn | input | 1 | Complement control, 1 inverts all data bits |
| latchEnN | input | 1 | Latch enable, low = transparent, high = hold |
| segOut | output | 12 | Latched driver lines: thermometer in 11:5, binary in 4:0 |

## Verification
Two events can coincide. One is the capture at the rising edge of the latch enable. The other is a change on the data or complement inputs directly after that edge. The bench raises the enable and, in the very next time step, changes both the data and the complement several times. The capture is judged correct only if the output keeps the encoding of the pre-edge inputs. It is also judged against the encoding of the new inputs, which must appear only once the enable goes low again.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int DATA_W   = 8;
  localparam int SEG_BITS = 3;
  localparam int BIN_BITS = DATA_W - SEG_BITS;
  localparam int SEG_LINES = (1 << SEG_BITS) - 1;
  localparam int OUT_W    = SEG_LINES + BIN_BITS;

  typedef struct packed {
    logic passEn;    // latch transparent
    logic invertEn;  // complement the data word
  } ctrlStrobe_t;
endpackage

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
  parameter int CODE_W = 3,
  localparam int LINES = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] codeIn,
  output logic [LINES-1:0]  thermOut
);
  for (genvar j = 0; j < LINES; j++) begin : g_line
    assign thermOut[j] = (codeIn > CODE_W'(j));
  end

  always_comb begin
    // R3
    therm_count_chk: assert final ($countones(thermOut) == int'(codeIn))
      else $error("thermometer count mismatch");
    for (int j = 0; j < LINES - 1; j++) begin
      // R3
      therm_shape_chk: assert final (!thermOut[j+1] || thermOut[j])
        else $error("thermometer not contiguous at line %0d", j);
    end
  end
endmodule

// File: rtl/seg_dac_ctrl.sv
module seg_dac_ctrl
  import seg_dac_pkg::*;
(
  input  logic        latchEnN,
  input  logic        compIn,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.passEn   = ~latchEnN;
    strobe.invertEn = compIn;
  end
endmodule

// File: rtl/seg_dac_datapath.sv
module seg_dac_datapath
  import seg_dac_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strobe,
  output logic [OUT_W-1:0]  latchQ
);
  logic [DATA_W-1:0]    procData;
  logic [SEG_LINES-1:0] thermLines;
  logic [OUT_W-1:0]     latchD;

  assign procData = dataIn ^ {DATA_W{strobe.invertEn}};

  seg_dac_therm #(.CODE_W(SEG_BITS)) therm_i (
    .codeIn  (procData[DATA_W-1 -: SEG_BITS]),
    .thermOut(thermLines)
  );

  assign latchD = {thermLines, procData[BIN_BITS-1:0]};

  always_latch begin
    if (strobe.passEn) latchQ <= latchD;
  end

  always_comb begin
    // R5
    latch_follow_chk: assert final (!strobe.passEn || latchQ == latchD)
      else $error("transparent latch does not follow its input");
  end
endmodule

// File: rtl/seg_dac_frontend.sv
module seg_dac_frontend
  import seg_dac_pkg::*;
(
  input  logic [7:0]  dataIn,
  input  logic        compIn,
  input  logic        latchEnN,
  output logic [11:0] segOut
);
  ctrlStrobe_t strobe;

  seg_dac_ctrl ctrl_i (
    .latchEnN(latchEnN),
    .compIn  (compIn),
    .strobe  (strobe)
  );

  seg_dac_datapath dp_i (
    .dataIn(dataIn),
    .strobe(strobe),
    .latchQ(segOut)
  );

  always_comb begin
    // R4
    bin_field_chk: assert final (latchEnN ||
        segOut[BIN_BITS-1:0] == (dataIn[BIN_BITS-1:0] ^ {BIN_BITS{compIn}}))
      else $error("binary field mismatch while transparent");
    // R2
    seg_field_chk: assert final (latchEnN ||
        $countones(segOut[OUT_W-1:BIN_BITS]) ==
        int'(dataIn[DATA_W-1 -: SEG_BITS] ^ {SEG_BITS{compIn}}))
      else $error("segment count mismatch while transparent");
  end
endmodule

// File: tb/seg_dac_frontend_tb_top.sv
module seg_dac_frontend_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic [7:0]  dataIn = '0;
  logic        compIn = 0;
  logic        latchEnN = 0;
  logic [11:0] segOut;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  seg_dac_frontend dut_i (
    .dataIn(dataIn), .compIn(compIn), .latchEnN(latchEnN), .segOut(segOut)
  );

  function automatic logic [11:0] expEnc(logic [7:0] d, logic c);
    logic [7:0] v;
    logic [11:0] r;
    v = d ^ {8{c}};
    r[4:0] = v[4:0];
    for (int j = 0; j < 7; j++) r[5+j] = (j < int'(v[7:5]));
    return r;
  endfunction

  task automatic check(string req, logic [11:0] exp);
    total++;
    if (segOut !== exp) begin
      bad++;
      $display("FAIL %s: segOut=%h expected=%h", req, segOut, exp);
    end
  endtask

  task automatic sweepTransparent(logic c);
    latchEnN = 0;
    compIn = c;
    for (int n = 0; n < 256; n++) begin
      dataIn = 8'(n);
      #2;
      check("R1 R2 R3 R4 R5", expEnc(8'(n), c));
    end
  endtask

  task automatic boundaryCodes();
    latchEnN = 0;
    compIn = 0; dataIn = 8'h1F; #2; check("R3 k=0", 12'h01F);
    compIn = 0; dataIn = 8'hE0; #2; check("R3 k=7", 12'hFE0);
    compIn = 1; dataIn = 8'hFF; #2; check("R2 all inverted", 12'h000);
    compIn = 1; dataIn = 8'h00; #2; check("R2 R3 all set", 12'hFFF);
    compIn = 0; dataIn = 8'hA5; #2; check("R4 binary field", expEnc(8'hA5, 0));
  endtask

  task automatic holdAcrossChanges();
    logic [11:0] held;
    latchEnN = 0; compIn = 0; dataIn = 8'h6B; #2;
    held = expEnc(8'h6B, 0);
    latchEnN = 1;
    #1; dataIn = 8'h00; compIn = 1;
    #2; check("R6 capture at edge", held);
    dataIn = 8'hFF; #2; check("R7 data ignored", held);
    compIn = 0; #2; check("R7 complement ignored", held);
    dataIn = 8'h31; compIn = 1; #2; check("R7 both ignored", held);
    latchEnN = 0; #2; check("R5 release follows", expEnc(8'h31, 1));
  endtask

  task automatic shortPulse();
    latchEnN = 0; compIn = 0; dataIn = 8'h12; #2;
    latchEnN = 1; #2;
    dataIn = 8'hC7; compIn = 0; #2;
    check("R8 still old", expEnc(8'h12, 0));
    latchEnN = 0; #1; latchEnN = 1;
    #1; dataIn = 8'h3C; compIn = 1; #2;
    check("R8 pulse loaded", expEnc(8'hC7, 0));
    latchEnN = 0; #1; latchEnN = 1;
    #1; dataIn = 8'h00; #2;
    check("R8 second pulse", expEnc(8'h3C, 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 0;
    #2;
    check("R5 initial transparent", expEnc(8'h00, 0));
    sweepTransparent(1'b0);
    sweepTransparent(1'b1);
    boundaryCodes();
    holdAcrossChanges();
    shortPulse();
    #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule